// File: doc/BRIEF.md
# Multi-cycle array mean calculator

This block finds the integer mean of a set of unsigned 32-bit samples. An internal sample store is filled through a write port while the block is idle. A start request then launches a run over the first N words. A small controller steers one shared arithmetic unit. For the length of the run it adds each stored word to a wide accumulator, one word per clock, starting at the lowest address. It then uses the same unit to divide the total by N.

When the quotient is ready the block raises `done`, and `done` stays high for as long as `start` is held. Dropping `start` returns the block to idle. The result stays on `mean_out` until the next run begins. A run with N = 0 does no division: it returns zero and raises `err` alongside `done`.

Top module: `array_mean_unit`

## Requirements
- R1: After reset `busy`, `done` and `err` are 0 and `mean_out` is 0.
- R2: `start` sampled high while idle begins a run, and `busy` is 1 from the following cycle until the block is idle again.
- R3: For N > 0 the result on `mean_out` equals floor(S / N). S is the exact sum of the N stored words, and it never wraps for any N up to the store depth.
- R4: A run reads the words at addresses 0 to N−1 only, so words at addresses N and above have no effect on the result.
- R5: For N > 0, `done` is first high N+3 rising edges after the edge that samples `start`. Those edges are one for clearing, N for summing, one for dividing, and one counting the start edge itself.
- R6: For N = 0, `done` is first high 2 edges after the start edge, with `err` = 1 and `mean_out` = 0.
- R7: For any run with N > 0, `err` is 0 when `done` is high, even if the previous run set it.
- R8: `done` stays high while `start` stays high. On the first edge that samples `start` low in that state, the block returns to idle and `done` and `busy` go to 0.
- R9: A write request while `busy` is 1 leaves the store unchanged.
- R10: A write request while idle stores `wr_data` at `wr_addr`, and the next run uses that word.
- R11: While idle, `mean_out` keeps the last result until the next run starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Store write request |
| wr_addr | input | log2(DEPTH) | Store write address |
| wr_data | input | DATA_W | Store write word |
| start | input | 1 | Run request; hold high until `done` to keep the result flagged |
| count | input | log2(DEPTH)+1 | Number of samples N, 0 to DEPTH |
| busy | output | 1 | High whenever the block is not idle |
| done | output | 1 | Result is valid |
| err | output | 1 | Last run had N = 0 |
| mean_out | output | DATA_W | Integer mean of the last run |

## Verification
The hardest case to reach is a write that arrives in the middle of a run and targets a word the run has not read yet. If the lock were missing, that write would change the result only in this narrow window. The stimulus launches a full-depth run and injects a write to the last address a few cycles after `start`. It then checks that the quotient matches the old contents, and checks again on a second run that the word itself was never replaced. Sweeping every N from 0 to the full depth of a 16-word configuration, with four data patterns, reaches the zero-length path, the boundary at full depth and sums near the accumulator limit.

// File: rtl/mean_pkg.sv
`timescale 1ns/1ps
package mean_pkg;
   typedef enum logic [1:0] {
      OP_ADD = 2'd0,
      OP_SUB = 2'd1,
      OP_MUL = 2'd2,
      OP_DIV = 2'd3
   } aluop_t;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CLEAR,
      ST_ACCUM,
      ST_DIVIDE,
      ST_DONE
   } fsm_t;
endpackage

// File: rtl/mean_alu.sv
`timescale 1ns/1ps
module mean_alu
   import mean_pkg::*;
#(
   parameter int W = 40
)(
   input  aluop_t       op,
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] y
);
   always_comb begin
      unique case (op)
         OP_ADD:  y = a + b;
         OP_SUB:  y = a - b;
         OP_MUL:  y = a * b;
         OP_DIV:  y = (b == '0) ? '0 : a / b;
         default: y = '0;
      endcase
   end
endmodule

// File: rtl/mean_store.sv
`timescale 1ns/1ps
module mean_store #(
   parameter int DEPTH  = 256,
   parameter int DATA_W = 32,
   localparam int ADDR_W = $clog2(DEPTH)
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lock,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data
);
   logic [DATA_W-1:0] words [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en && !lock)
         words[wr_addr] <= wr_data;
   end

   assign rd_data = words[rd_addr];

   p_locked_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && lock) |=> (words[$past(wr_addr)] == $past(words[wr_addr])))
      else $error("write landed while run active");
endmodule

// File: rtl/mean_ctrl.sv
`timescale 1ns/1ps
module mean_ctrl
   import mean_pkg::*;
#(
   parameter int DEPTH = 256,
   localparam int ADDR_W = $clog2(DEPTH),
   localparam int CNT_W  = ADDR_W + 1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [CNT_W-1:0]  count,
   output aluop_t            op,
   output logic              sel_n,
   output logic              acc_clr,
   output logic              acc_en,
   output logic              busy,
   output logic              done,
   output logic              err,
   output logic [ADDR_W-1:0] addr,
   output logic [CNT_W-1:0]  n_val
);
   fsm_t             state;
   logic [CNT_W-1:0] n_reg;
   logic             err_q;
   logic             last;

   assign last = ({1'b0, addr} == (n_reg - CNT_W'(1)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         addr  <= '0;
         n_reg <= '0;
         err_q <= 1'b0;
      end else begin
         unique case (state)
            ST_IDLE: if (start) begin
               n_reg <= count;
               err_q <= 1'b0;
               state <= ST_CLEAR;
            end
            ST_CLEAR: begin
               addr <= '0;
               if (n_reg == '0) begin
                  err_q <= 1'b1;
                  state <= ST_DONE;
               end else begin
                  state <= ST_ACCUM;
               end
            end
            ST_ACCUM: begin
               addr <= addr + ADDR_W'(1);
               if (last) state <= ST_DIVIDE;
            end
            ST_DIVIDE: state <= ST_DONE;
            ST_DONE:   if (!start) state <= ST_IDLE;
            default:   state <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      op      = OP_ADD;
      sel_n   = 1'b0;
      acc_clr = 1'b0;
      acc_en  = 1'b0;
      unique case (state)
         ST_CLEAR:  acc_clr = 1'b1;
         ST_ACCUM:  acc_en  = 1'b1;
         ST_DIVIDE: begin
            acc_en = 1'b1;
            op     = OP_DIV;
            sel_n  = 1'b1;
         end
         default: ;
      endcase
   end

   assign busy  = (state != ST_IDLE);
   assign done  = (state == ST_DONE);
   assign err   = err_q;
   assign n_val = n_reg;

   p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE && start) |=> (state == ST_CLEAR && busy))
      else $error("start not taken");
   p_addr_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_ACCUM) |-> ({1'b0, addr} < n_reg))
      else $error("read past N-1");
   p_zero_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_CLEAR && n_reg == '0) |=> (done && err))
      else $error("zero length not flagged");
   p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_DONE && !start) |=> !busy)
      else $error("no return to idle");
endmodule

// File: rtl/array_mean_unit.sv
`timescale 1ns/1ps
module array_mean_unit
   import mean_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 256,
   parameter int ACC_W  = DATA_W + $clog2(DEPTH),
   localparam int ADDR_W = $clog2(DEPTH),
   localparam int CNT_W  = ADDR_W + 1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              start,
   input  logic [CNT_W-1:0]  count,
   output logic              busy,
   output logic              done,
   output logic              err,
   output logic [DATA_W-1:0] mean_out
);
   if (DEPTH < 2 || (1 << ADDR_W) != DEPTH) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 2");
   end
   if (ACC_W < DATA_W + ADDR_W) begin : g_bad_acc
      $error("ACC_W too narrow to hold a full-depth sum");
   end

   aluop_t            op;
   logic              sel_n, acc_clr, acc_en;
   logic [ADDR_W-1:0] rd_addr;
   logic [CNT_W-1:0]  n_val;
   logic [DATA_W-1:0] sample;
   logic [ACC_W-1:0]  operand, alu_y, acc;

   mean_ctrl #(.DEPTH(DEPTH)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start), .count(count),
      .op(op), .sel_n(sel_n), .acc_clr(acc_clr), .acc_en(acc_en),
      .busy(busy), .done(done), .err(err), .addr(rd_addr), .n_val(n_val)
   );

   mean_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
      .clk(clk), .rst_n(rst_n), .lock(busy), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(sample)
   );

   assign operand = sel_n ? ACC_W'(n_val) : ACC_W'(sample);

   mean_alu #(.W(ACC_W)) u_alu (
      .op(op), .a(acc), .b(operand), .y(alu_y)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       acc <= '0;
      else if (acc_clr) acc <= '0;
      else if (acc_en)  acc <= alu_y;
   end

   assign mean_out = acc[DATA_W-1:0];

   p_sum_grows_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_en && op == OP_ADD) |=> (acc >= $past(acc)))
      else $error("accumulator wrapped");
   p_zero_result_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (done && err) |-> (mean_out == '0))
      else $error("nonzero result on empty run");
   p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |=> $stable(mean_out))
      else $error("result moved while idle");
endmodule

// File: tb/array_mean_unit_test.sv
`timescale 1ns/1ps
module array_mean_unit_test;
   localparam int DW = 32;
   localparam int DP = 16;
   localparam int AW = $clog2(DP);
   localparam int CW = AW + 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic          start = 1'b0;
   logic [CW-1:0] count = '0;
   logic          busy, done, err;
   logic [DW-1:0] mean_out;

   int vectors = 0;
   int errors  = 0;
   logic [DW-1:0] model [DP];

   array_mean_unit #(.DATA_W(DW), .DEPTH(DP)) uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .start(start), .count(count),
      .busy(busy), .done(done), .err(err), .mean_out(mean_out)
   );

   always #5 clk = ~clk;

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      vectors++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic put(input int a, input logic [DW-1:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      model[a] = d;
   endtask

   function automatic logic [DW-1:0] expect_mean(input int n);
      longint s = 0;
      for (int i = 0; i < n; i++) s += longint'(model[i]);
      return (n == 0) ? '0 : DW'(s / n);
   endfunction

   task automatic run(input int n, input bit poke);
      int cyc = 0;
      logic [DW-1:0] exp = expect_mean(n);
      bit busy_seen = 0;
      @(negedge clk);
      count = CW'(n); start = 1'b1;
      while (cyc < 100) begin
         @(posedge clk); #1; cyc++;
         if (cyc == 1) busy_seen = busy;
         if (poke && cyc == 3) begin
            wr_en = 1'b1; wr_addr = AW'(DP-1); wr_data = ~model[DP-1];
         end
         if (poke && cyc == 4) wr_en = 1'b0;
         if (done) break;
      end
      chk(busy_seen, "R2 busy after start", busy_seen, 1);
      if (n == 0) begin
         chk(cyc == 2, "R6 latency", cyc, 2);
         chk(err == 1'b1, "R6 err", err, 1);
         chk(mean_out == '0, "R6 result", mean_out, 0);
      end else begin
         chk(cyc == n + 3, "R5 latency", cyc, n + 3);
         chk(err == 1'b0, "R7 err clear", err, 0);
         chk(mean_out == exp, poke ? "R9 locked write" : "R3 R4 mean", mean_out, exp);
      end
      @(negedge clk); @(negedge clk);
      chk(done == 1'b1, "R8 done held", done, 1);
      start = 1'b0;
      @(posedge clk); #1;
      chk(!done && !busy, "R8 back to idle", {done, busy}, 0);
      repeat (3) @(posedge clk);
      #1;
      chk(mean_out == exp, "R11 result held", mean_out, exp);
   endtask

   initial begin
      #2_000_000;
      errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin
      logic [DW-1:0] lcg = 32'h1234_5678;
      repeat (3) @(negedge clk);
      #1;
      chk(!busy && !done && !err && mean_out == '0, "R1 reset state",
          {busy, done, err}, 0);
      rst_n = 1'b1;
      for (int p = 0; p < 4; p++) begin
         for (int i = 0; i < DP; i++) begin
            logic [DW-1:0] d;
            case (p)
               0: d = 32'hFFFF_FFFF;
               1: d = DW'(i) * 32'h1000_0001 + 32'd7;
               2: begin lcg = lcg * 32'd1664525 + 32'd1013904223; d = lcg; end
               default: d = (i % 2 == 0) ? 32'd0 : 32'd3;
            endcase
            put(i, d);  // R10 stores while idle
         end
         for (int n = 0; n <= DP; n++) run(n, 1'b0);
      end
      run(DP, 1'b1);
      run(DP, 1'b0);  // R9 word unchanged
      put(0, 32'd100); put(1, 32'd201);
      run(2, 1'b0);   // R10 new words used
      chk(mean_out == 32'd150, "R10 fresh write", mean_out, 150);
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end
endmodule